// File: doc/BRIEF.md
# Hardwired control sequencer for a 4-bit-opcode accumulator machine

This block is the control unit of a small single-bus accumulator machine. It runs a short, variable-length sequence of steps for every instruction. The instruction register supplies a 4-bit opcode, and the flags register supplies latched carry and zero bits. In each clock cycle the block drives a 16-bit control word. The surrounding datapath (program counter, address register, memory, A and B registers, adder, output register) uses those strobes to move one value across the bus and load it where the instruction needs it.

Every instruction starts with the same two fetch steps. After those come zero to three execute steps, chosen by the opcode and, for the two conditional jumps, by the latched flags. The step counter goes back to the first fetch step right after an instruction's last used step. A halt instruction moves the sequencer into a frozen state, and only reset leaves it.

The sequencer's states are named as follows. FETCH_ADDR drives the first fetch step. FETCH_INSN drives the second. EXEC_A, EXEC_B and EXEC_C are execute steps 3, 4 and 5. HALTED is the frozen state. The transitions are:

- FETCH_ADDR goes to FETCH_INSN.
- FETCH_INSN goes to EXEC_A.
- EXEC_A goes to EXEC_B for load, add, subtract and store, and to HALTED for halt. Every other opcode goes from EXEC_A to FETCH_ADDR.
- EXEC_B goes to EXEC_C for add and subtract. Every other opcode goes from EXEC_B to FETCH_ADDR.
- EXEC_C goes to FETCH_ADDR.
- HALTED stays in HALTED.
- Reset forces FETCH_ADDR.

Top module: `ctl_sequencer`

## Requirements
- R1: While reset is held and just after it is released, the sequencer is in its first fetch step. The control word `ctl_o` has these bit positions: 0 PC_OUT, 1 MAR_LOAD, 2 MEM_OUT, 3 IR_LOAD, 4 PC_INC, 5 IR_OUT, 6 MEM_WRITE, 7 A_LOAD, 8 A_OUT, 9 B_LOAD, 10 SUM_OUT, 11 SUB_MODE, 12 FLAG_LOAD, 13 OUT_LOAD, 14 PC_JUMP, 15 HALT.
- R2: Every instruction begins with step 1 {PC_OUT, MAR_LOAD} and then step 2 {MEM_OUT, IR_LOAD, PC_INC}. Neither step depends on the opcode or flag inputs.
- R3: Load (0001) uses step 3 {IR_OUT, MAR_LOAD} and step 4 {MEM_OUT, A_LOAD}. Add (0010) uses step 3 {IR_OUT, MAR_LOAD}, step 4 {MEM_OUT, B_LOAD} and step 5 {SUM_OUT, A_LOAD, FLAG_LOAD}. Subtract (0011) is the same as add, with SUB_MODE also set in step 5. After its last step, each of these returns to step 1.
- R4: Store (0100) uses step 3 {IR_OUT, MAR_LOAD} and step 4 {A_OUT, MEM_WRITE}, then returns to step 1.
- R5: Immediate load (0101) uses the single step {IR_OUT, A_LOAD}. Jump (0110) uses the single step {IR_OUT, PC_JUMP}. Output (1110) uses the single step {A_OUT, OUT_LOAD}. Each then returns to step 1.
- R6: Jump-on-carry (0111) and jump-on-zero (1000) sample their flag input in step 3. If the flag is set, step 3 is {IR_OUT, PC_JUMP}. If it is clear, step 3 is empty. Either way the next step is step 1.
- R7: No-operation (0000) and the unassigned opcodes 1001 to 1101 have an empty step 3 and then return to step 1.
- R8: Halt (1111) drives a step 3 of only HALT. From then on the control word stays at only HALT whatever the opcode and flags do, until reset.
- R9: In every step at most one of PC_OUT, MEM_OUT, IR_OUT, A_OUT and SUM_OUT is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 4 | Opcode field held in the instruction register |
| carry_i | input | 1 | Latched carry flag |
| zero_i | input | 1 | Latched zero flag |
| ctl_o | output | 16 | Control strobes, bit positions as in R1 |

## Verification
The control word is decoded combinationally from the step register. A step's strobes are therefore valid for the whole cycle after the rising edge that enters the step, and they react within that same cycle to the opcode and flags. The bench samples `ctl_o` at each falling edge, once per step, and compares it with the word it computes for that step. It changes opcode and flags only after sampling, which mimics an instruction register that loads at the end of step 2. During both fetch steps and the halted state the bench drives junk opcodes and flags, so that any dependence on them shows up in the next sample. After the halt step it keeps watching several cycles, and after reset it checks that step 1 comes back at once.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OPC_W = 4;
    localparam int CW_W  = 16;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR = 3'd0,
        ST_FETCH_INSN = 3'd1,
        ST_EXEC_A     = 3'd2,
        ST_EXEC_B     = 3'd3,
        ST_EXEC_C     = 3'd4,
        ST_HALTED     = 3'd5
    } step_e;

    localparam logic [OPC_W-1:0] OPC_NOP    = 4'b0000;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_ADD    = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_SUB    = 4'b0011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 4'b0100;
    localparam logic [OPC_W-1:0] OPC_LOADI  = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_JUMP   = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_JCARRY = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_JZERO  = 4'b1000;
    localparam logic [OPC_W-1:0] OPC_OUT    = 4'b1110;
    localparam logic [OPC_W-1:0] OPC_HALT   = 4'b1111;

    localparam int CW_PC_OUT    = 0;
    localparam int CW_MAR_LOAD  = 1;
    localparam int CW_MEM_OUT   = 2;
    localparam int CW_IR_LOAD   = 3;
    localparam int CW_PC_INC    = 4;
    localparam int CW_IR_OUT    = 5;
    localparam int CW_MEM_WRITE = 6;
    localparam int CW_A_LOAD    = 7;
    localparam int CW_A_OUT     = 8;
    localparam int CW_B_LOAD    = 9;
    localparam int CW_SUM_OUT   = 10;
    localparam int CW_SUB_MODE  = 11;
    localparam int CW_FLAG_LOAD = 12;
    localparam int CW_OUT_LOAD  = 13;
    localparam int CW_PC_JUMP   = 14;
    localparam int CW_HALT      = 15;

    // Opcodes that use a second execute step
    function automatic logic needs_step_b(input logic [OPC_W-1:0] op);
        return (op == OPC_LOAD) || (op == OPC_ADD) ||
               (op == OPC_SUB)  || (op == OPC_STORE);
    endfunction

    // Opcodes that use a third execute step
    function automatic logic needs_step_c(input logic [OPC_W-1:0] op);
        return (op == OPC_ADD) || (op == OPC_SUB);
    endfunction

    // Whether the jump strobe fires for this opcode and these flags
    function automatic logic jump_taken(input logic [OPC_W-1:0] op,
                                        input logic carry,
                                        input logic zero);
        return (op == OPC_JUMP) ||
               ((op == OPC_JCARRY) && carry) ||
               ((op == OPC_JZERO) && zero);
    endfunction

endpackage

// File: rtl/ctl_step_reg.sv
module ctl_step_reg
    import ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  step_e step_nxt,
    output step_e step_cur
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cur <= ST_FETCH_ADDR;
        end else begin
            step_cur <= step_nxt;
        end
    end

endmodule

// File: rtl/ctl_next_step.sv
module ctl_next_step
    import ctl_pkg::*;
(
    input  step_e            step_cur,
    input  logic [OPC_W-1:0] opcode,
    output step_e            step_nxt
);

    always_comb begin
        step_nxt = ST_FETCH_ADDR;
        unique case (step_cur)
            ST_FETCH_ADDR: step_nxt = ST_FETCH_INSN;
            ST_FETCH_INSN: step_nxt = ST_EXEC_A;
            ST_EXEC_A: begin
                if (opcode == OPC_HALT) begin
                    step_nxt = ST_HALTED;
                end else if (needs_step_b(opcode)) begin
                    step_nxt = ST_EXEC_B;
                end else begin
                    step_nxt = ST_FETCH_ADDR;
                end
            end
            ST_EXEC_B: begin
                if (needs_step_c(opcode)) begin
                    step_nxt = ST_EXEC_C;
                end else begin
                    step_nxt = ST_FETCH_ADDR;
                end
            end
            ST_EXEC_C: step_nxt = ST_FETCH_ADDR;
            ST_HALTED: step_nxt = ST_HALTED;
            default:   step_nxt = ST_FETCH_ADDR;
        endcase
    end

endmodule

// File: rtl/ctl_word_gen.sv
module ctl_word_gen
    import ctl_pkg::*;
(
    input  step_e            step_cur,
    input  logic [OPC_W-1:0] opcode,
    input  logic             carry,
    input  logic             zero,
    output logic [CW_W-1:0]  cw
);

    always_comb begin
        cw = '0;
        unique case (step_cur)
            ST_FETCH_ADDR: begin
                cw[CW_PC_OUT]   = 1'b1;
                cw[CW_MAR_LOAD] = 1'b1;
            end
            ST_FETCH_INSN: begin
                cw[CW_MEM_OUT] = 1'b1;
                cw[CW_IR_LOAD] = 1'b1;
                cw[CW_PC_INC]  = 1'b1;
            end
            ST_EXEC_A: begin
                case (opcode)
                    OPC_LOAD, OPC_ADD, OPC_SUB, OPC_STORE: begin
                        cw[CW_IR_OUT]   = 1'b1;
                        cw[CW_MAR_LOAD] = 1'b1;
                    end
                    OPC_LOADI: begin
                        cw[CW_IR_OUT] = 1'b1;
                        cw[CW_A_LOAD] = 1'b1;
                    end
                    OPC_JUMP, OPC_JCARRY, OPC_JZERO: begin
                        if (jump_taken(opcode, carry, zero)) begin
                            cw[CW_IR_OUT]  = 1'b1;
                            cw[CW_PC_JUMP] = 1'b1;
                        end
                    end
                    OPC_OUT: begin
                        cw[CW_A_OUT]    = 1'b1;
                        cw[CW_OUT_LOAD] = 1'b1;
                    end
                    OPC_HALT: cw[CW_HALT] = 1'b1;
                    default: ;
                endcase
            end
            ST_EXEC_B: begin
                case (opcode)
                    OPC_LOAD: begin
                        cw[CW_MEM_OUT] = 1'b1;
                        cw[CW_A_LOAD]  = 1'b1;
                    end
                    OPC_ADD, OPC_SUB: begin
                        cw[CW_MEM_OUT] = 1'b1;
                        cw[CW_B_LOAD]  = 1'b1;
                    end
                    OPC_STORE: begin
                        cw[CW_A_OUT]     = 1'b1;
                        cw[CW_MEM_WRITE] = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_EXEC_C: begin
                cw[CW_SUM_OUT]   = 1'b1;
                cw[CW_A_LOAD]    = 1'b1;
                cw[CW_FLAG_LOAD] = 1'b1;
                cw[CW_SUB_MODE]  = (opcode == OPC_SUB);
            end
            ST_HALTED: cw[CW_HALT] = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
    import ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  opcode_i,
    input  logic        carry_i,
    input  logic        zero_i,
    output logic [15:0] ctl_o
);

    step_e step_cur;
    step_e step_nxt;

    ctl_step_reg u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_nxt (step_nxt),
        .step_cur (step_cur)
    );

    ctl_next_step u_next (
        .step_cur (step_cur),
        .opcode   (opcode_i),
        .step_nxt (step_nxt)
    );

    ctl_word_gen u_word (
        .step_cur (step_cur),
        .opcode   (opcode_i),
        .carry    (carry_i),
        .zero     (zero_i),
        .cw       (ctl_o)
    );

endmodule

// File: rtl/ctl_sequencer_chk.sv
module ctl_sequencer_chk
    import ctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [OPC_W-1:0] opcode_i,
    input logic             carry_i,
    input logic             zero_i,
    input logic [CW_W-1:0]  ctl_o
);

    localparam logic [CW_W-1:0] W_FETCH1 = (CW_W'(1) << CW_PC_OUT) | (CW_W'(1) << CW_MAR_LOAD);
    localparam logic [CW_W-1:0] W_FETCH2 = (CW_W'(1) << CW_MEM_OUT) | (CW_W'(1) << CW_IR_LOAD) |
                                           (CW_W'(1) << CW_PC_INC);
    localparam logic [CW_W-1:0] W_HALT   = CW_W'(1) << CW_HALT;

    // R2: the first fetch step is always followed by the second
    a_r2_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o == W_FETCH1) |=> (ctl_o == W_FETCH2));

    // R2: the second fetch step is always followed by an execute step
    a_r2_exec_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o == W_FETCH2) |=> (!ctl_o[CW_PC_OUT] && !ctl_o[CW_IR_LOAD]));

    // R3: the step that drives the sum ends its instruction
    a_r3_sum_ends: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o[CW_SUM_OUT] |=> (ctl_o == W_FETCH1));

    // R5: a jump step ends its instruction
    a_r5_jump_ends: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o[CW_PC_JUMP] |=> (ctl_o == W_FETCH1));

    // R6: conditional jumps fire only with their flag set
    a_r6_carry_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[CW_PC_JUMP] && (opcode_i == OPC_JCARRY)) |-> carry_i);

    a_r6_zero_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[CW_PC_JUMP] && (opcode_i == OPC_JZERO)) |-> zero_i);

    // R8: once halted, only the halt strobe stays on
    a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o[CW_HALT] |=> (ctl_o == W_HALT));

    // R9: never more than one bus driver
    a_r9_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_o[CW_PC_OUT], ctl_o[CW_MEM_OUT], ctl_o[CW_IR_OUT],
                  ctl_o[CW_A_OUT], ctl_o[CW_SUM_OUT]}));

endmodule

bind ctl_sequencer ctl_sequencer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode_i (opcode_i),
    .carry_i  (carry_i),
    .zero_i   (zero_i),
    .ctl_o    (ctl_o)
);

// File: tb/ctl_sequencer_test.sv
`timescale 1ns/1ps
module ctl_sequencer_test;

    // Bit positions of the control word (R1)
    localparam int B_CO = 0,  B_MI = 1,  B_RO = 2,  B_II = 3;
    localparam int B_CI = 4,  B_IO = 5,  B_RI = 6,  B_AI = 7;
    localparam int B_AO = 8,  B_BI = 9,  B_SO = 10, B_SU = 11;
    localparam int B_FI = 12, B_OI = 13, B_J  = 14, B_HL = 15;

    localparam logic [3:0] T_NOP = 4'd0,  T_LDA = 4'd1, T_ADD = 4'd2, T_SUB = 4'd3;
    localparam logic [3:0] T_STA = 4'd4,  T_LDI = 4'd5, T_JMP = 4'd6, T_JC  = 4'd7;
    localparam logic [3:0] T_JZ  = 4'd8,  T_OUT = 4'd14, T_HLT = 4'd15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode_i = 4'd0;
    logic        carry_i = 1'b0;
    logic        zero_i = 1'b0;
    logic [15:0] ctl_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ctl_sequencer uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode_i (opcode_i),
        .carry_i  (carry_i),
        .zero_i   (zero_i),
        .ctl_o    (ctl_o)
    );

    function automatic logic [15:0] bit_of(input int b);
        return 16'(1) << b;
    endfunction

    function automatic logic [15:0] exp_word(input logic [3:0] op, input int k,
                                             input bit c, input bit z);
        logic [15:0] w = '0;
        if (k == 1) w = bit_of(B_CO) | bit_of(B_MI);
        else if (k == 2) w = bit_of(B_RO) | bit_of(B_II) | bit_of(B_CI);
        else if (k == 3) begin
            case (op)
                T_LDA, T_ADD, T_SUB, T_STA: w = bit_of(B_IO) | bit_of(B_MI);
                T_LDI: w = bit_of(B_IO) | bit_of(B_AI);
                T_JMP: w = bit_of(B_IO) | bit_of(B_J);
                T_JC:  w = c ? (bit_of(B_IO) | bit_of(B_J)) : 16'h0;
                T_JZ:  w = z ? (bit_of(B_IO) | bit_of(B_J)) : 16'h0;
                T_OUT: w = bit_of(B_AO) | bit_of(B_OI);
                T_HLT: w = bit_of(B_HL);
                default: w = 16'h0;
            endcase
        end else if (k == 4) begin
            case (op)
                T_LDA: w = bit_of(B_RO) | bit_of(B_AI);
                T_ADD, T_SUB: w = bit_of(B_RO) | bit_of(B_BI);
                T_STA: w = bit_of(B_AO) | bit_of(B_RI);
                default: w = 16'h0;
            endcase
        end else if (k == 5) begin
            w = bit_of(B_SO) | bit_of(B_AI) | bit_of(B_FI);
            if (op == T_SUB) w |= bit_of(B_SU);
        end
        return w;
    endfunction

    function automatic int insn_len(input logic [3:0] op);
        case (op)
            T_LDA, T_STA: return 4;
            T_ADD, T_SUB: return 5;
            default:      return 3;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op, input int k);
        if (k <= 2) return "R2";
        case (op)
            T_LDA, T_ADD, T_SUB: return "R3";
            T_STA:               return "R4";
            T_LDI, T_JMP, T_OUT: return "R5";
            T_JC, T_JZ:          return "R6";
            T_HLT:               return "R8";
            default:             return "R7";
        endcase
    endfunction

    task automatic check_word(input logic [15:0] exp, input string req);
        logic [4:0] drv;
        checks++;
        if (ctl_o !== exp) begin
            errors++;
            $display("FAIL %s: ctl_o=%h expected=%h opcode=%h", req, ctl_o, exp, opcode_i);
        end
        drv = {ctl_o[B_CO], ctl_o[B_RO], ctl_o[B_IO], ctl_o[B_AO], ctl_o[B_SO]};
        checks++;
        if ($countones(drv) > 1) begin
            errors++;
            $display("FAIL R9: bus drivers=%b expected at most one set", drv);
        end
    endtask

    // Entered at a falling edge with the machine in step 1; leaves the
    // same way, one instruction later.
    task automatic run_insn(input logic [3:0] op, input bit c, input bit z);
        int n = insn_len(op);
        for (int k = 1; k <= n; k++) begin
            check_word(exp_word(op, k, c, z), req_of(op, k));
            if (k == 1) begin
                opcode_i = 4'($urandom_range(0, 15));
                carry_i  = 1'($urandom_range(0, 1));
                zero_i   = 1'($urandom_range(0, 1));
            end else if (k == 2) begin
                opcode_i = op;
                carry_i  = c;
                zero_i   = z;
            end
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic reset_and_check();
        rst_n = 1'b0;
        opcode_i = 4'($urandom_range(0, 15));
        @(posedge clk);
        @(negedge clk);
        check_word(bit_of(B_CO) | bit_of(B_MI), "R1");
        rst_n = 1'b1;
    endtask

    task automatic run_halt(input int hold);
        run_insn(T_HLT, 1'b0, 1'b0);   // three samples: fetch, fetch, halt
        for (int i = 0; i < hold; i++) begin
            opcode_i = 4'($urandom_range(0, 15));
            carry_i  = 1'($urandom_range(0, 1));
            zero_i   = 1'($urandom_range(0, 1));
            @(posedge clk);
            @(negedge clk);
            check_word(bit_of(B_HL), "R8");
        end
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'd4711);
        @(negedge clk);
        reset_and_check();
        // Directed: every opcode with every flag pair (R3 to R7)
        for (int op = 0; op < 15; op++) begin
            for (int f = 0; f < 4; f++) begin
                run_insn(4'(op), f[1], f[0]);
            end
        end
        // R6 corner: flag of the other jump kind set, own flag clear
        run_insn(T_JC, 1'b0, 1'b1);
        run_insn(T_JZ, 1'b1, 1'b0);
        // Random instruction stream
        for (int i = 0; i < 500; i++) begin
            logic [3:0] op = 4'($urandom_range(0, 14));
            run_insn(op, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        // R8 halt, then R1 reset recovers and R2 fetch resumes
        run_halt(10);
        reset_and_check();
        run_insn(T_ADD, 1'b0, 1'b0);
        run_insn(T_JC, 1'b1, 1'b0);
        run_halt(6);
        reset_and_check();
        run_insn(T_STA, 1'b0, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule